// File: doc/BRIEF.md
# Split-Priority Interrupt Collector

This block gathers sixteen peripheral interrupt sources into one status word and gates them with a mask register. It then drives two request lines toward a processor core. Sources in bits 0 to 3 form the fast group and raise `fiq`. Sources in bits 4 to 15 raise `irq`. Both lines are registered and active high.

Some sources are plain levels that the status word follows, and some are latched events that stay set until software acknowledges them. Each latched event is cleared by its own acknowledge path:
- Each of five event sources has its own write-only acknowledge address.
- The serial-converter completion bit is cleared by a strobe that marks a read of the converter's received data.

Each timer source is set on a falling edge of that timer's clock, sampled in the system clock domain, while the timer reports a zero count.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset the mask is zero, every latched status bit is zero, and `fiq` and `irq` are low.
- R2: A write to word address 1 stores `wdata[15:0]` as the mask (1 = enabled). A read of address 1 returns the mask with bits 31:16 reading zero.
- R3: A read of word address 0 returns the raw status in bits 15:0 whatever the mask holds, with zero in bits 31:16.
- R4: Status bits 0-7, 12 and 13 copy `src_lvl` one clock after it is sampled. `src_evt` at those positions has no effect.
- R5: A one-cycle high on `src_evt` bit 10, 11, 14 or 15 sets that status bit, which stays set after the pulse. `src_lvl` at bits 8-11, 14 and 15 has no effect, and neither has `src_evt` at bits 8 and 9.
- R6: Status bit 8+t (t = 0 or 1) is set when `tmr_clk[t]` was high at one clock edge and is low at the next while `tmr_zero[t]` is high. A rising timer clock, or a fall with `tmr_zero[t]` low, sets nothing.
- R7: Writes to word addresses 2, 3, 4, 5 and 6 clear status bits 8, 9, 10, 11 and 14 in that order. No other bit is touched and the write data is ignored.
- R8: `sse_rd` high for one cycle clears status bit 15. No acknowledge address clears bit 15.
- R9: When a latched bit is set and cleared in the same cycle, it ends up set.
- R10: `fiq` is the OR of status AND mask over bits 0-3, and `irq` is the same over bits 4-15. Both are registered and reflect the inputs and any mask write one clock edge later.
- R11: A source whose mask bit is zero never raises `fiq` or `irq`.
- R12: Writes to address 0 and to unmapped addresses (7 and up) change no state. Reads of addresses 2 and up return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Register word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational from `addr` |
| src_lvl | input | N_SRC (16) | Level source inputs |
| src_evt | input | N_SRC (16) | Single-cycle event set pulses |
| tmr_clk | input | N_TMR (2) | Timer clocks, sampled on `clk` |
| tmr_zero | input | N_TMR (2) | Timer count-is-zero flags |
| sse_rd | input | 1 | Converter data read, clears bit 15 |
| fiq | output | 1 | Fast interrupt request |
| irq | output | 1 | Normal interrupt request |

## Verification
The bench drives an acknowledge and a new event for the same bit in the same cycle. A design that lets the clear win would silently lose an interrupt. It toggles the timer clocks in both directions with the zero flag high and low. This catches a design that triggers on the rising edge or ignores the zero flag, which would fire early or without cause. It sends acknowledges to every address while the converter bit is pending, and drives levels and pulses into the wrong source classes. A decode that is off by one or merges the two classes would then clear or set bits it must leave alone. It moves the mask across the fast/normal boundary to catch a split at the wrong bit, which would route a source to the wrong request line.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int A_STAT = 0;
    localparam int A_MASK = 1;
    localparam int A_EOI0 = 2;
    localparam int EOI_N  = 5;
    localparam int EOI_BIT [EOI_N] = '{8, 9, 10, 11, 14};
    localparam int TMR_BIT0 = 8;
    localparam int SSE_BIT  = 15;
    localparam logic [15:0] LATCH_SET = 16'hCF00;
    localparam logic [15:0] EVT_SET   = 16'hCC00;
    localparam logic [15:0] FIQ_SET   = 16'h000F;
endpackage

// File: rtl/icu_tclk_edge.sv
module icu_tclk_edge #(
    parameter int N_TMR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TMR-1:0] tmr_clk,
    input  logic [N_TMR-1:0] tmr_zero,
    output logic [N_TMR-1:0] uf_set
);
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        logic prev_d, prev_q;

        always_comb begin
            prev_d = tmr_clk[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= prev_d;
        end

        assign uf_set[g] = prev_q & ~tmr_clk[g] & tmr_zero[g];
    end
endmodule

// File: rtl/icu_bus_dec.sv
module icu_bus_dec
    import icu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int N_SRC  = 16
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              mask_we,
    output logic [N_SRC-1:0]  eoi_clr
);
    always_comb begin
        mask_we = wr && (addr == ADDR_W'(A_MASK));
        eoi_clr = '0;
        for (int k = 0; k < EOI_N; k++) begin
            if (wr && (addr == ADDR_W'(A_EOI0 + k))) eoi_clr[EOI_BIT[k]] = 1'b1;
        end
    end
endmodule

// File: rtl/icu_status.sv
module icu_status
    import icu_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int N_TMR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lvl,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_TMR-1:0] uf_set,
    input  logic [N_SRC-1:0] eoi_clr,
    input  logic             sse_rd,
    output logic [N_SRC-1:0] st_d,
    output logic [N_SRC-1:0] st_q
);
    localparam logic [N_SRC-1:0] LATCH = N_SRC'(LATCH_SET);
    localparam logic [N_SRC-1:0] EVTM  = N_SRC'(EVT_SET);

    logic [N_SRC-1:0] set_v, clr_v;

    always_comb begin
        set_v = evt & EVTM;
        for (int t = 0; t < N_TMR; t++) begin
            set_v[TMR_BIT0 + t] = set_v[TMR_BIT0 + t] | uf_set[t];
        end
        clr_v = eoi_clr;
        clr_v[SSE_BIT] = clr_v[SSE_BIT] | sse_rd;
        for (int i = 0; i < N_SRC; i++) begin
            if (LATCH[i]) st_d[i] = set_v[i] | (st_q[i] & ~clr_v[i]);
            else          st_d[i] = lvl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
    import icu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int N_SRC  = 16,
    parameter int N_TMR  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_SRC-1:0]  src_lvl,
    input  logic [N_SRC-1:0]  src_evt,
    input  logic [N_TMR-1:0]  tmr_clk,
    input  logic [N_TMR-1:0]  tmr_zero,
    input  logic              sse_rd,
    output logic              fiq,
    output logic              irq
);
    localparam logic [N_SRC-1:0] FIQM = N_SRC'(FIQ_SET);

    typedef struct packed {
        logic [N_SRC-1:0] mask;
        logic             fiq;
        logic             irq;
    } ctl_t;

    ctl_t             d, q;
    logic             mask_we;
    logic [N_SRC-1:0] eoi_clr, st_d, st_q, msk_q;
    logic [N_TMR-1:0] uf_set;

    icu_tclk_edge #(.N_TMR(N_TMR)) u_edge (
        .clk(clk), .rst_n(rst_n), .tmr_clk(tmr_clk), .tmr_zero(tmr_zero), .uf_set(uf_set)
    );

    icu_bus_dec #(.ADDR_W(ADDR_W), .N_SRC(N_SRC)) u_dec (
        .wr(wr), .addr(addr), .mask_we(mask_we), .eoi_clr(eoi_clr)
    );

    icu_status #(.N_SRC(N_SRC), .N_TMR(N_TMR)) u_stat (
        .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .evt(src_evt), .uf_set(uf_set),
        .eoi_clr(eoi_clr), .sse_rd(sse_rd), .st_d(st_d), .st_q(st_q)
    );

    always_comb begin
        d = q;
        if (mask_we) d.mask = wdata[N_SRC-1:0];
        d.fiq = |(st_d & d.mask & FIQM);
        d.irq = |(st_d & d.mask & ~FIQM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (addr == ADDR_W'(A_STAT))      rdata = DATA_W'(st_q);
        else if (addr == ADDR_W'(A_MASK)) rdata = DATA_W'(q.mask);
        else                              rdata = '0;
    end

    assign msk_q = q.mask;
    assign fiq   = q.fiq;
    assign irq   = q.irq;
endmodule

// File: rtl/irq_fiq_ctrl_chk.sv
module irq_fiq_ctrl_chk #(
    parameter int ADDR_W = 4,
    parameter int N_SRC  = 16,
    parameter int N_TMR  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [N_SRC-1:0]  src_lvl,
    input logic [N_SRC-1:0]  src_evt,
    input logic [N_TMR-1:0]  tmr_clk,
    input logic [N_TMR-1:0]  tmr_zero,
    input logic              sse_rd,
    input logic              fiq,
    input logic              irq,
    input logic [N_SRC-1:0]  st,
    input logic [N_SRC-1:0]  msk
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!fiq && !irq && msk == '0));

    // R2
    mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == ADDR_W'(1)) |=> $stable(msk));

    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st[0] == $past(src_lvl[0])));

    // R5
    rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[10] && !(wr && addr == ADDR_W'(4))) |=> st[10]);

    // R6
    tmr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(tmr_clk[0]) && tmr_zero[0]) |=> st[8]);

    // R8
    sse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[15] && !sse_rd) |=> st[15]);

    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt[11] |=> st[11]);

    // R11
    masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msk == '0 && !(wr && addr == ADDR_W'(1))) |=> (!fiq && !irq));
endmodule

bind irq_fiq_ctrl irq_fiq_ctrl_chk #(.ADDR_W(ADDR_W), .N_SRC(N_SRC), .N_TMR(N_TMR)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .src_lvl(src_lvl), .src_evt(src_evt),
    .tmr_clk(tmr_clk), .tmr_zero(tmr_zero), .sse_rd(sse_rd), .fiq(fiq), .irq(irq),
    .st(st_q), .msk(msk_q)
);

// File: tb/irq_fiq_ctrl_bench.sv
module irq_fiq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] src_lvl = '0, src_evt = '0;
    logic [1:0]  tmr_clk = '0, tmr_zero = '0;
    logic        sse_rd = 1'b0;
    logic        fiq, irq;

    always #10 clk = ~clk;

    irq_fiq_ctrl u_irq_fiq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
        .src_lvl(src_lvl), .src_evt(src_evt), .tmr_clk(tmr_clk), .tmr_zero(tmr_zero),
        .sse_rd(sse_rd), .fiq(fiq), .irq(irq)
    );

    typedef struct {
        string       tag;
        logic [31:0] rd;
        logic        f;
        logic        i;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0, errors = 0;
    logic [15:0] m_st = '0, m_mask = '0;
    logic [1:0]  m_prev = '0;
    logic [15:0] cur_lv = '0;
    logic [1:0]  cur_tc = '0, cur_tz = '0;

    // driver: apply one cycle of stimulus and predict the outputs after the edge
    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] wd,
                        input logic [15:0] ev, input logic sc, input string tag);
        logic [15:0] clr, setv;
        exp_t e;
        @(negedge clk);
        wr = w; addr = a; wdata = wd; src_evt = ev; sse_rd = sc;
        src_lvl = cur_lv; tmr_clk = cur_tc; tmr_zero = cur_tz;
        clr = '0;
        if (w) begin
            case (a)
                4'd2: clr[8] = 1'b1;
                4'd3: clr[9] = 1'b1;
                4'd4: clr[10] = 1'b1;
                4'd5: clr[11] = 1'b1;
                4'd6: clr[14] = 1'b1;
                default: ;
            endcase
        end
        if (sc) clr[15] = 1'b1;
        setv = ev & 16'hCC00;
        setv[8] = m_prev[0] & ~cur_tc[0] & cur_tz[0];
        setv[9] = m_prev[1] & ~cur_tc[1] & cur_tz[1];
        m_st = (cur_lv & ~16'hCF00) | setv | (m_st & 16'hCF00 & ~clr);
        if (w && a == 4'd1) m_mask = wd[15:0];
        m_prev = cur_tc;
        e.tag = tag;
        e.rd  = (a == 4'd0) ? {16'h0, m_st} : (a == 4'd1) ? {16'h0, m_mask} : 32'h0;
        e.f   = |(m_st & m_mask & 16'h000F);
        e.i   = |(m_st & m_mask & 16'hFFF0);
        @(posedge clk);
        sbq.push_back(e);
    endtask

    // monitor: compare design outputs shortly after each edge
    always @(posedge clk) begin
        exp_t e;
        #2;
        while (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (rdata !== e.rd || fiq !== e.f || irq !== e.i) begin
                errors++;
                $display("FAIL %s: rdata=%h fiq=%b irq=%b expected rdata=%h fiq=%b irq=%b",
                         e.tag, rdata, fiq, irq, e.rd, e.f, e.i);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (fiq !== 1'b0 || irq !== 1'b0 || rdata !== 32'h0) begin
            errors++;
            $display("FAIL R1 in reset: fiq=%b irq=%b rdata=%h expected 0 0 0", fiq, irq, rdata);
        end
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1 status after reset");
        step(0, 1, 0, 0, 0, "R1 mask after reset");
        step(1, 1, 32'hFFFF_FFFF, 0, 0, "R2 mask write, upper bits read zero");
        cur_lv = 16'h0001; step(0, 0, 0, 0, 0, "R4 R10 level bit0 raises fiq");
        cur_lv = 16'h1000; step(0, 0, 0, 16'h1000, 0, "R4 R10 level bit12 raises irq, evt ignored");
        cur_lv = 16'hFFFF; step(0, 0, 0, 0, 0, "R4 R5 levels at latched bits ignored");
        cur_lv = 16'h0000; step(0, 0, 0, 16'hFFFF, 0, "R5 event pulses latch");
        step(0, 0, 0, 0, 0, "R5 latched bits hold");
        step(1, 4, 32'hFFFF_FFFF, 0, 0, "R7 ack rtc clears bit10");
        step(1, 5, 0, 0, 0, "R7 ack tick clears bit11");
        step(1, 6, 0, 0, 0, "R7 ack modem clears bit14");
        step(1, 2, 0, 0, 0, "R7 R8 timer ack leaves bit15");
        step(1, 3, 0, 0, 0, "R8 timer2 ack leaves bit15");
        step(1, 0, 32'hFFFF, 0, 0, "R12 status write ignored");
        step(1, 7, 32'hFFFF, 0, 0, "R12 unmapped write ignored");
        step(0, 0, 0, 0, 0, "R12 state intact after writes");
        step(0, 0, 0, 0, 1, "R8 converter read clears bit15");
        cur_tc = 2'b11; cur_tz = 2'b01; step(0, 0, 0, 0, 0, "R6 rising timer clock sets nothing");
        cur_tc = 2'b00; step(0, 0, 0, 0, 0, "R6 fall sets timer1, timer2 zero low");
        cur_tz = 2'b10; cur_tc = 2'b10; step(0, 0, 0, 0, 0, "R6 timer2 rise");
        cur_tc = 2'b00; step(0, 0, 0, 0, 0, "R6 timer2 fall sets bit9");
        step(1, 2, 0, 0, 0, "R7 ack timer1 clears bit8");
        step(1, 3, 0, 0, 0, "R7 ack timer2 clears bit9");
        step(1, 4, 0, 16'h0400, 0, "R9 set wins over ack from clear");
        step(1, 4, 0, 16'h0400, 0, "R9 set wins over ack while set");
        step(1, 4, 0, 0, 0, "R7 ack alone clears bit10");
        cur_lv = 16'h00F0; step(1, 1, 32'h0, 0, 0, "R11 mask zero blocks irq");
        cur_lv = 16'h0002; step(1, 1, 32'h0002, 0, 0, "R10 fiq from bit1");
        step(1, 1, 32'h0010, 0, 0, "R11 bit1 masked drops fiq");
        cur_lv = 16'h0012; step(0, 1, 0, 0, 0, "R10 irq from bit4 only");
        step(0, 0, 0, 0, 0, "R3 status ignores mask");
        step(0, 6, 0, 0, 0, "R12 ack address reads zero");
        repeat (3) @(posedge clk);
        #3;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule